// File: doc/BRIEF.md
# ADC Result Magnitude Compare Interrupt

This block sits beside an analog-to-digital converter and watches every conversion result the converter reports. Each result arrives as a one-cycle valid strobe together with a channel number and a 12-bit unsigned value. The block has no notion of conversion groups. It inspects every result, whichever group sequence produced it. Only results whose channel number equals the programmed watch channel are compared.

A compare tests either "result at or above the reference" or "result strictly below the reference". The reference comes from one of two sources. It can be a programmable constant. It can also be the newest result seen from a second programmable channel, which the block captures itself. When the compare holds, a sticky hit flag sets. The interrupt line is that flag gated by an enable bit. Software clears the flag by writing a 1 to a dedicated clear address.

Configuration uses a simple write port with the following map:
- Address 0 is the mode register. Bit 0 selects the direction (0 = at-or-above, 1 = below). Bit 1 selects the reference source (0 = constant, 1 = channel). Bit 2 is the interrupt enable.
- Address 1 holds the watch channel.
- Address 2 holds the reference channel.
- Address 3 holds the constant reference.
- Address 4 is the flag-clear port.

Top module: `magcmp_unit`

## Requirements
- R1: After reset the flag and the interrupt are 0, and every configuration field is 0: at-or-above direction, constant source, interrupt disabled, both channels 0, constant reference 0.
- R2: A result is compared only when its valid strobe is high and its channel number equals the watch channel (address 1). Any other result leaves the flag unchanged.
- R3: With mode bit 0 = 0, a compared result sets the flag at the clock edge that samples it when result >= reference. Equality counts as a hit.
- R4: With mode bit 0 = 1, a compared result sets the flag only when result < reference. Equality is not a hit.
- R5: With mode bit 1 = 0, the reference is the constant at address 3. Both values are compared as unsigned 12-bit numbers, so 0xFFF >= 0x800 is a hit.
- R6: With mode bit 1 = 1, the reference is the newest result captured from the reference channel (address 2). Until that channel has reported once, no compare takes place and the flag does not set.
- R7: A write to any of addresses 0 to 3 discards the captured reference. A reference-channel result that arrives in the same cycle as such a write is not captured.
- R8: The flag stays set until a write to address 4 with data bit 0 = 1 clears it. A write to address 4 with bit 0 = 0 has no effect. A configuration write to addresses 0 to 3 does not touch the flag.
- R9: When a hit and a flag-clear write occur in the same cycle, the flag ends up set.
- R10: The interrupt output equals the flag ANDed with mode bit 2. It follows a change of either at the same edge at which that change registers.
- R11: When the watch channel and the reference channel are the same in channel mode, each result is compared against the value captured before it, and then replaces that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resValid | input | 1 | Conversion result valid strobe |
| resChan | input | 5 | Channel number of the result |
| resData | input | 12 | Unsigned conversion value |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration write address |
| cfgWrData | input | 12 | Configuration write data |
| cmpFlag | output | 1 | Sticky compare hit flag |
| cmpIrq | output | 1 | Interrupt request (flag AND enable) |

## Verification
Two pairs of events can fall in the same cycle, and each pair is driven on purpose in a single clock.

The first pair is a hit together with a flag-clear write. The bench drives a matching result that satisfies the compare and a clear write to address 4 in the same cycle. It then expects the flag to read 1 at the next sample, because the set must win.

The second pair is a reference-channel capture together with a configuration write. The bench presents a reference-channel result in the same cycle as a write to the constant register. A following watch-channel result that would be a hit must then leave the flag at 0, which shows that the capture was discarded.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE     = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_WATCH    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_REFCHAN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CONST    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAGCLR  = 3'd4;

  localparam int MODE_DIR_BIT = 0;
  localparam int MODE_SRC_BIT = 1;
  localparam int MODE_IRQ_BIT = 2;

  // strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic cmpHit;   // result belongs to the watch channel
    logic refLoad;  // result belongs to the reference channel, capture it
    logic refDrop;  // configuration changed, discard captured reference
    logic flagClr;  // software clear of the hit flag
  } strobe_t;

endpackage

// File: rtl/magcmp_ctrl.sv
module magcmp_ctrl
  import magcmp_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [CHAN_W-1:0] resChan,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output strobe_t           strb,
  output logic              dirBelow,
  output logic              refFromChan,
  output logic              irqEn,
  output logic [CHAN_W-1:0] watchChan,
  output logic [DATA_W-1:0] constRef
);

  logic [CHAN_W-1:0] refChan;
  logic              cfgTouch;

  // a write to any of the four configuration registers
  assign cfgTouch = cfgWrEn && (cfgAddr <= ADDR_CONST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirBelow    <= 1'b0;
      refFromChan <= 1'b0;
      irqEn       <= 1'b0;
      watchChan   <= '0;
      refChan     <= '0;
      constRef    <= '0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        ADDR_MODE: begin
          dirBelow    <= cfgWrData[MODE_DIR_BIT];
          refFromChan <= cfgWrData[MODE_SRC_BIT];
          irqEn       <= cfgWrData[MODE_IRQ_BIT];
        end
        ADDR_WATCH:   watchChan <= cfgWrData[CHAN_W-1:0];
        ADDR_REFCHAN: refChan   <= cfgWrData[CHAN_W-1:0];
        ADDR_CONST:   constRef  <= cfgWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.cmpHit  = resValid && (resChan == watchChan);
    strb.refLoad = resValid && (resChan == refChan) && !cfgTouch;
    strb.refDrop = cfgTouch;
    strb.flagClr = cfgWrEn && (cfgAddr == ADDR_FLAGCLR) && cfgWrData[0];
  end

endmodule

// File: rtl/magcmp_dp.sv
module magcmp_dp
  import magcmp_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] resData,
  input  logic              dirBelow,
  input  logic              refFromChan,
  input  logic [DATA_W-1:0] constRef,
  output logic              cmpFlag
);

  logic [DATA_W-1:0] capRef;
  logic              capValid;
  logic [DATA_W-1:0] useRef;
  logic              refReady;
  logic              condMet;
  logic              setFlag;

  // captured reference-channel value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capRef   <= '0;
      capValid <= 1'b0;
    end else if (strb.refDrop) begin
      capValid <= 1'b0;
    end else if (strb.refLoad) begin
      capRef   <= resData;
      capValid <= 1'b1;
    end
  end

  // unsigned compare against the selected reference
  always_comb begin
    useRef   = refFromChan ? capRef : constRef;
    refReady = !refFromChan || capValid;
    condMet  = dirBelow ? (resData < useRef) : (resData >= useRef);
    setFlag  = strb.cmpHit && refReady && condMet;
  end

  // sticky flag, a hit wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cmpFlag <= 1'b0;
    else if (setFlag)      cmpFlag <= 1'b1;
    else if (strb.flagClr) cmpFlag <= 1'b0;
  end

endmodule

// File: rtl/magcmp_unit.sv
module magcmp_unit
  import magcmp_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [CHAN_W-1:0] resChan,
  input  logic [DATA_W-1:0] resData,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic              cmpFlag,
  output logic              cmpIrq
);

  strobe_t           strb;
  logic              dirBelow;
  logic              refFromChan;
  logic              irqEn;
  logic [CHAN_W-1:0] watchChan;
  logic [DATA_W-1:0] constRef;

  magcmp_ctrl #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .resValid   (resValid),
    .resChan    (resChan),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgWrData  (cfgWrData),
    .strb       (strb),
    .dirBelow   (dirBelow),
    .refFromChan(refFromChan),
    .irqEn      (irqEn),
    .watchChan  (watchChan),
    .constRef   (constRef)
  );

  magcmp_dp #(.DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .resData    (resData),
    .dirBelow   (dirBelow),
    .refFromChan(refFromChan),
    .constRef   (constRef),
    .cmpFlag    (cmpFlag)
  );

  assign cmpIrq = cmpFlag & irqEn;

endmodule

// File: rtl/magcmp_checker.sv
module magcmp_checker #(
  parameter int CHAN_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              resValid,
  input logic [CHAN_W-1:0] resChan,
  input logic              cfgWrEn,
  input logic [2:0]        cfgAddr,
  input logic              clrBit,
  input logic [CHAN_W-1:0] watchChan,
  input logic              cmpFlag,
  input logic              cmpIrq
);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    cmpIrq |-> cmpFlag);  // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (cmpFlag && !(cfgWrEn && cfgAddr == 3'd4 && clrBit)) |=> cmpFlag);  // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == 3'd4 && clrBit && !resValid) |=> !cmpFlag);  // R8

  AST_RISE_ON_WATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpFlag) |-> $past(resValid && resChan == watchChan));  // R2

  AST_CFG_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr <= 3'd3 && !resValid) |=> $stable(cmpFlag));  // R8

endmodule

bind magcmp_unit magcmp_checker #(.CHAN_W(CHAN_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .resValid (resValid),
  .resChan  (resChan),
  .cfgWrEn  (cfgWrEn),
  .cfgAddr  (cfgAddr),
  .clrBit   (cfgWrData[0]),
  .watchChan(watchChan),
  .cmpFlag  (cmpFlag),
  .cmpIrq   (cmpIrq)
);

// File: tb/tb_magcmp_unit.sv
`timescale 1ns/1ps
module tb_magcmp_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic [4:0]  resChan = '0;
  logic [11:0] resData = '0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [11:0] cfgWrData = '0;
  logic        cmpFlag;
  logic        cmpIrq;

  int nChecks = 0;
  int nFail = 0;

  typedef struct {
    logic  expFlag;
    logic  expIrq;
    string req;
  } exp_t;

  exp_t sbq[$];

  always #2.5 clk = ~clk;

  magcmp_unit dut (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan),
    .resData(resData), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cmpFlag(cmpFlag), .cmpIrq(cmpIrq)
  );

  // monitor: compare registered outputs midway between edges
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      nChecks++;
      if (cmpFlag !== e.expFlag || cmpIrq !== e.expIrq) begin
        nFail++;
        $display("FAIL %s: flag/irq got %b/%b expected %b/%b",
                 e.req, cmpFlag, cmpIrq, e.expFlag, e.expIrq);
      end
    end
  end

  // driver: one clock of stimulus, expectation for the state after the edge
  task automatic step(input logic v, input logic [4:0] ch, input logic [11:0] d,
                      input logic w, input logic [2:0] a, input logic [11:0] wd,
                      input logic ef, input logic ei, input string req);
    resValid  = v;
    resChan   = ch;
    resData   = d;
    cfgWrEn   = w;
    cfgAddr   = a;
    cfgWrData = wd;
    @(posedge clk);
    sbq.push_back('{ef, ei, req});
    #1;
    resValid = 1'b0;
    cfgWrEn  = 1'b0;
  endtask

  task automatic res(input logic [4:0] ch, input logic [11:0] d,
                     input logic ef, input logic ei, input string req);
    step(1'b1, ch, d, 1'b0, 3'd0, 12'd0, ef, ei, req);
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] wd,
                    input logic ef, input logic ei, input string req);
    step(1'b0, 5'd0, 12'd0, 1'b1, a, wd, ef, ei, req);
  endtask

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("%0d/%0d checks passed", nChecks + 1 - nFail, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    nChecks++;
    if (cmpFlag !== 1'b0 || cmpIrq !== 1'b0) begin
      nFail++;
      $display("FAIL R1 reset: flag/irq got %b/%b expected 0/0", cmpFlag, cmpIrq);
    end
    @(posedge clk); #1;

    // R1: default config is at-or-above a constant 0 on channel 0
    res(5'd0, 12'h000, 1, 0, "R1 default hit");
    wr(3'd4, 12'h001, 0, 0, "R8 clear");

    wr(3'd3, 12'h800, 0, 0, "R8 cfg keeps flag");
    wr(3'd1, 12'd5,   0, 0, "R8 cfg keeps flag");
    wr(3'd0, 12'b100, 0, 0, "R10 enable");
    res(5'd3, 12'hFFF, 0, 0, "R2 other channel ignored");
    res(5'd5, 12'h7FF, 0, 0, "R3 below no hit");
    res(5'd5, 12'h800, 1, 1, "R3 equal is hit");
    wr(3'd4, 12'h000, 1, 1, "R8 clear bit0=0 ignored");
    res(5'd5, 12'h000, 1, 1, "R8 sticky");
    wr(3'd4, 12'h001, 0, 0, "R8 clear");
    res(5'd5, 12'hFFF, 1, 1, "R5 unsigned compare");
    wr(3'd4, 12'h001, 0, 0, "R8 clear");

    // R4: below direction
    wr(3'd0, 12'b101, 0, 0, "R4 set below");
    res(5'd5, 12'h800, 0, 0, "R4 equal not hit");
    res(5'd5, 12'h7FF, 1, 1, "R4 below hit");
    wr(3'd4, 12'h001, 0, 0, "R8 clear");

    // R10: interrupt gating
    wr(3'd0, 12'b001, 0, 0, "R10 disable");
    res(5'd5, 12'h000, 1, 0, "R10 flag without irq");
    wr(3'd0, 12'b101, 1, 1, "R10 enable raises irq");
    wr(3'd0, 12'b001, 1, 0, "R10 disable drops irq");
    wr(3'd4, 12'h001, 0, 0, "R8 clear");

    // R9: hit and clear in one cycle
    step(1'b1, 5'd5, 12'h000, 1'b1, 3'd4, 12'h001, 1, 0, "R9 set wins");
    wr(3'd4, 12'h001, 0, 0, "R8 clear");

    // R6: channel reference
    wr(3'd2, 12'd9, 0, 0, "R6 ref chan");
    wr(3'd0, 12'b110, 0, 0, "R6 chan mode");
    res(5'd5, 12'hFFF, 0, 0, "R6 no ref yet");
    res(5'd9, 12'h400, 0, 0, "R6 capture");
    res(5'd5, 12'h3FF, 0, 0, "R6 below captured");
    res(5'd5, 12'h400, 1, 1, "R6 equal captured");
    wr(3'd4, 12'h001, 0, 0, "R8 clear");
    res(5'd9, 12'h100, 0, 0, "R6 recapture");
    res(5'd5, 12'h200, 1, 1, "R6 newest ref used");
    wr(3'd4, 12'h001, 0, 0, "R8 clear");

    // R7: config writes discard the captured reference
    wr(3'd3, 12'h000, 0, 0, "R7 cfg write");
    res(5'd5, 12'hFFF, 0, 0, "R7 ref discarded");
    step(1'b1, 5'd9, 12'h010, 1'b1, 3'd3, 12'h000, 0, 0, "R7 collide");
    res(5'd5, 12'hFFF, 0, 0, "R7 collided capture dropped");
    res(5'd9, 12'h010, 0, 0, "R7 capture");
    res(5'd5, 12'h010, 1, 1, "R7 capture used");
    wr(3'd4, 12'h001, 0, 0, "R8 clear");

    // R11: watch channel equals reference channel
    wr(3'd1, 12'd9, 0, 0, "R11 watch=ref");
    res(5'd9, 12'h500, 0, 0, "R11 first only captures");
    res(5'd9, 12'h4FF, 0, 0, "R11 vs previous 0x500");
    res(5'd9, 12'h4FF, 1, 1, "R11 vs previous 0x4FF");
    wr(3'd4, 12'h001, 0, 0, "R8 clear");

    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule